// File: doc/BRIEF.md
# PCI Target Window Decoder with Sub-Window Error Handling

This block sits behind a PCI target port and classifies each incoming target address against a small set of base address windows. Each window has a base, a size mask and a disable bit, and owns a group of finer sub-windows that route the access to a back-end target. Every access ends in one of three outcomes:
- **Full hit:** the address falls in a window and in one of its sub-windows. The cycle is claimed and routed to that sub-window.
- **Sub-window miss:** the address falls in a window but in none of its sub-windows. The cycle is claimed, but reads return a fixed junk word and writes are discarded.
- **Window miss:** the address falls in no enabled window. The cycle is not claimed at all.

A sub-window miss also records its address in an error register and raises a sticky interrupt cause bit. Software clears that bit with a write-one-to-clear strobe. The decode result is registered. It appears on the response outputs for exactly one clock, one cycle after the address strobe.

Top module: `pci_bar_decoder`

## Requirements
- R1: The decode result is registered. `rsp_vld` is 1 in exactly the cycle after a cycle with `addr_vld` = 1, and 0 otherwise. The other response outputs are only non-zero while `rsp_vld` is 1.
- R2: Window `b` matches when `(addr & mask_b) == (base_b & mask_b)`. When several windows match, the lowest index wins, and `rsp_bar` reports that index.
- R3: A 1 in bit `b` of `bar_dis` disables window `b`, so it never matches. A 0 in that bit lets it decode.
- R4: Sub-window `s` of the selected window matches under the same masked compare, with the lowest index winning. On a full hit, `rsp_claim` = 1, `rsp_sub_hit` = 1 and `rsp_sub` gives the sub-window index. A full-hit read returns `tgt_data` on `rd_data`.
- R5: A read that matches a window but none of its sub-windows is claimed (`rsp_claim` = 1, `rsp_sub_hit` = 0) and returns 0xDEADBEEF on `rd_data`.
- R6: `rsp_wr_fwd` is 1 only for a full-hit write. A write that misses the sub-windows is claimed but not forwarded.
- R7: An access that matches no enabled window leaves `rsp_claim`, `rsp_sub_hit` and `rsp_wr_fwd` at 0, and `rd_data` at 0.
- R8: A sub-window miss (read or write) sets `memout` in the same cycle its response appears. If `memout` was clear, it also loads the access address into `err_addr`.
- R9: While `memout` stays set, further sub-window misses leave `err_addr` unchanged.
- R10: A `memout_clr` pulse clears `memout` one cycle later. If a sub-window miss is decoded in the same cycle as the clear, the miss wins: `memout` stays 1 and `err_addr` takes the new address.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Address strobe, one cycle per access |
| addr | input | AW | Target address |
| is_write | input | 1 | 1 = write access, 0 = read access |
| bar_base | input | NB*AW | Window bases, window 0 in the low bits |
| bar_mask | input | NB*AW | Window compare masks (1 = bit compared) |
| bar_dis | input | NB | Per-window disable, 1 = disabled |
| sub_base | input | NB*NS*AW | Sub-window bases, slot b*NS+s |
| sub_mask | input | NB*NS*AW | Sub-window compare masks, slot b*NS+s |
| memout_clr | input | 1 | Write-one-to-clear strobe for `memout` |
| tgt_data | input | DW | Read data from the routed back-end target |
| rsp_vld | output | 1 | Decode result valid |
| rsp_claim | output | 1 | Cycle is claimed |
| rsp_sub_hit | output | 1 | Access hit a sub-window |
| rsp_wr_fwd | output | 1 | Write data is forwarded to the target |
| rsp_bar | output | BW | Index of the selected window |
| rsp_sub | output | SW | Index of the selected sub-window |
| rd_data | output | DW | Read data: target data, junk word or 0 |
| memout | output | 1 | Sticky sub-window-miss interrupt cause |
| err_addr | output | AW | First address that missed the sub-windows |

## Verification
Each access is strobed for one cycle. Its response, the `memout` flag and any `err_addr` update are all due one clock later, so the bench samples them on the falling edge that follows the capturing rising edge. The bench samples again one cycle after that to confirm the response has dropped back to idle. A clear strobe alone is checked one cycle after it is applied. A clear that coincides with a new miss is checked in the same response cycle as that miss. Expected outcomes come from address-range arithmetic over a sweep of upper nibbles, offsets, both directions and all four disable patterns.

// File: rtl/pci_bar_dec_pkg.sv
package pci_bar_dec_pkg;

    localparam logic [31:0] JUNK_WORD = 32'hDEAD_BEEF;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_FULL    = 2'd1,
        KIND_SUBMISS = 2'd2
    } decode_kind_e;

endpackage

// File: rtl/first_one.sv
module first_one #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/window_bank.sv
module window_bank #(
    parameter int N  = 4,
    parameter int AW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [AW-1:0]   addr,
    input  logic [N*AW-1:0] bases,
    input  logic [N*AW-1:0] masks,
    input  logic [N-1:0]    off,
    output logic            any_hit,
    output logic [IW-1:0]   hit_idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [AW-1:0] b_w, m_w;
        assign b_w        = bases[g*AW +: AW];
        assign m_w        = masks[g*AW +: AW];
        assign hit_vec[g] = !off[g] && ((addr & m_w) == (b_w & m_w));
    end

    first_one #(.N(N)) u_pick (
        .req   (hit_vec),
        .found (any_hit),
        .idx   (hit_idx)
    );
endmodule

// File: rtl/pci_bar_decoder.sv
module pci_bar_decoder
    import pci_bar_dec_pkg::*;
#(
    parameter int NB = 2,
    parameter int NS = 2,
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_vld,
    input  logic [AW-1:0]    addr,
    input  logic             is_write,
    input  logic [NB*AW-1:0] bar_base,
    input  logic [NB*AW-1:0] bar_mask,
    input  logic [NB-1:0]    bar_dis,
    input  logic [NB*NS*AW-1:0] sub_base,
    input  logic [NB*NS*AW-1:0] sub_mask,
    input  logic             memout_clr,
    input  logic [DW-1:0]    tgt_data,
    output logic             rsp_vld,
    output logic             rsp_claim,
    output logic             rsp_sub_hit,
    output logic             rsp_wr_fwd,
    output logic [BW-1:0]    rsp_bar,
    output logic [SW-1:0]    rsp_sub,
    output logic [DW-1:0]    rd_data,
    output logic             memout,
    output logic [AW-1:0]    err_addr
);

    typedef struct packed {
        logic          vld;
        decode_kind_e  kind;
        logic          wr;
        logic [BW-1:0] bar;
        logic [SW-1:0] sub;
        logic          memout;
        logic [AW-1:0] err_addr;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic          bar_any;
    logic [BW-1:0] bar_idx;
    logic [NB-1:0] sub_any;
    logic [SW-1:0] sub_idx_arr [NB];

    window_bank #(.N(NB), .AW(AW)) u_bars (
        .addr    (addr),
        .bases   (bar_base),
        .masks   (bar_mask),
        .off     (bar_dis),
        .any_hit (bar_any),
        .hit_idx (bar_idx)
    );

    for (genvar b = 0; b < NB; b++) begin : g_sub
        window_bank #(.N(NS), .AW(AW)) u_subs (
            .addr    (addr),
            .bases   (sub_base[b*NS*AW +: NS*AW]),
            .masks   (sub_mask[b*NS*AW +: NS*AW]),
            .off     ({NS{1'b0}}),
            .any_hit (sub_any[b]),
            .hit_idx (sub_idx_arr[b])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = addr_vld;
        st_d.kind = KIND_NONE;
        st_d.wr   = 1'b0;
        st_d.bar  = '0;
        st_d.sub  = '0;
        if (memout_clr) begin
            st_d.memout = 1'b0;
        end
        if (addr_vld && bar_any) begin
            st_d.wr  = is_write;
            st_d.bar = bar_idx;
            if (sub_any[bar_idx]) begin
                st_d.kind = KIND_FULL;
                st_d.sub  = sub_idx_arr[bar_idx];
            end else begin
                st_d.kind = KIND_SUBMISS;
                if (!st_d.memout) begin
                    st_d.err_addr = addr;
                end
                st_d.memout = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_vld     = st_q.vld;
    assign rsp_claim   = (st_q.kind != KIND_NONE);
    assign rsp_sub_hit = (st_q.kind == KIND_FULL);
    assign rsp_wr_fwd  = (st_q.kind == KIND_FULL) && st_q.wr;
    assign rsp_bar     = st_q.bar;
    assign rsp_sub     = st_q.sub;
    assign memout      = st_q.memout;
    assign err_addr    = st_q.err_addr;

    always_comb begin
        case (st_q.kind)
            KIND_FULL:    rd_data = tgt_data;
            KIND_SUBMISS: rd_data = DW'(JUNK_WORD);
            default:      rd_data = '0;
        endcase
    end

    assert_rsp_follows_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |=> rsp_vld);
    assert_no_rsp_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> !rsp_vld && !rsp_claim);
    assert_all_disabled_no_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && (&bar_dis)) |=> !rsp_claim);
    assert_write_only_full_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_fwd |-> rsp_sub_hit && rsp_claim);
    assert_submiss_sets_memout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_claim && !rsp_sub_hit) |-> memout);
    assert_err_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (memout && !memout_clr) |=> memout && $stable(err_addr));

endmodule

// File: tb/test_pci_bar_decoder.sv
module test_pci_bar_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_vld = 1'b0;
    logic [31:0] addr = '0;
    logic        is_write = 1'b0;
    logic [63:0] bar_base, bar_mask;
    logic [1:0]  bar_dis = 2'b00;
    logic [127:0] sub_base, sub_mask;
    logic        memout_clr = 1'b0;
    logic [31:0] tgt_data = 32'hCAFE_0001;
    logic        rsp_vld, rsp_claim, rsp_sub_hit, rsp_wr_fwd;
    logic [0:0]  rsp_bar, rsp_sub;
    logic [31:0] rd_data, err_addr;
    logic        memout;

    int n_chk = 0;
    int n_err = 0;
    logic        m_memout = 1'b0;
    logic [31:0] m_err = '0;

    always #10 clk = ~clk;

    assign bar_base = {32'h2000_0000, 32'h1000_0000};
    assign bar_mask = {32'hFFFF_0000, 32'hF000_0000};
    assign sub_base = {32'h2000_8000, 32'h2000_0000, 32'h1000_2000, 32'h1000_0000};
    assign sub_mask = {32'hFFFF_8000, 32'hFFFF_FF00, 32'hFFFF_F000, 32'hFFFF_F000};

    pci_bar_decoder i_pci_bar_decoder (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr(addr), .is_write(is_write),
        .bar_base(bar_base), .bar_mask(bar_mask), .bar_dis(bar_dis),
        .sub_base(sub_base), .sub_mask(sub_mask), .memout_clr(memout_clr),
        .tgt_data(tgt_data), .rsp_vld(rsp_vld), .rsp_claim(rsp_claim),
        .rsp_sub_hit(rsp_sub_hit), .rsp_wr_fwd(rsp_wr_fwd), .rsp_bar(rsp_bar),
        .rsp_sub(rsp_sub), .rd_data(rd_data), .memout(memout), .err_addr(err_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Reference outcome from address ranges
    task automatic model(input logic [31:0] a, input logic [1:0] dis,
                         output bit claim, output bit full, output int b, output int s);
        claim = 0; full = 0; b = 0; s = 0;
        if (!dis[0] && a >= 32'h1000_0000 && a <= 32'h1FFF_FFFF) begin
            claim = 1; b = 0;
            if (a >= 32'h1000_0000 && a <= 32'h1000_0FFF) begin full = 1; s = 0; end
            else if (a >= 32'h1000_2000 && a <= 32'h1000_2FFF) begin full = 1; s = 1; end
        end else if (!dis[1] && a >= 32'h2000_0000 && a <= 32'h2000_FFFF) begin
            claim = 1; b = 1;
            if (a <= 32'h2000_00FF) begin full = 1; s = 0; end
            else if (a >= 32'h2000_8000) begin full = 1; s = 1; end
        end
    endtask

    task automatic access(input logic [31:0] a, input bit w, input bit clr);
        bit claim, full;
        int b, s;
        logic [31:0] exp_rd;
        model(a, bar_dis, claim, full, b, s);
        @(negedge clk);
        addr = a; is_write = w; addr_vld = 1'b1; memout_clr = clr;
        @(negedge clk);
        addr_vld = 1'b0; memout_clr = 1'b0;
        if (clr) m_memout = 1'b0;
        if (claim && !full) begin
            if (!m_memout) m_err = a;
            m_memout = 1'b1;
        end
        chk("R1 rsp_vld", {31'b0, rsp_vld}, 32'd1);
        chk((bar_dis != 2'b00) ? "R3 claim" : "R2 claim", {31'b0, rsp_claim}, {31'b0, claim});
        chk("R4 sub_hit", {31'b0, rsp_sub_hit}, {31'b0, full});
        if (claim) chk("R2 bar index", {31'b0, rsp_bar}, b);
        if (full) chk("R4 sub index", {31'b0, rsp_sub}, s);
        chk(claim ? "R6 wr_fwd" : "R7 wr_fwd", {31'b0, rsp_wr_fwd}, {31'b0, full && w});
        if (!w) begin
            exp_rd = full ? tgt_data : (claim ? 32'hDEAD_BEEF : 32'h0);
            chk(full ? "R4 rd_data" : (claim ? "R5 rd_data" : "R7 rd_data"), rd_data, exp_rd);
        end
        chk(clr ? "R10 memout" : "R8 memout", {31'b0, memout}, {31'b0, m_memout});
        chk("R9 err_addr", err_addr, m_err);
        @(negedge clk);
        chk("R1 idle vld", {31'b0, rsp_vld}, 32'd0);
        chk("R1 idle claim", {31'b0, rsp_claim}, 32'd0);
    endtask

    task automatic clear();
        @(negedge clk);
        memout_clr = 1'b1;
        @(negedge clk);
        memout_clr = 1'b0;
        m_memout = 1'b0;
        chk("R10 clear", {31'b0, memout}, 32'd0);
    endtask

    function automatic logic [31:0] off_of(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0080;
            2: return 32'h0000_1000;
            3: return 32'h0000_2010;
            4: return 32'h0000_3000;
            5: return 32'h0000_8000;
            6: return 32'h0000_FF00;
            default: return 32'h0001_0000;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int cnt;
        cnt = 0;
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 vld", {31'b0, rsp_vld}, 32'd0);
        chk("R11 claim", {31'b0, rsp_claim}, 32'd0);
        chk("R11 memout", {31'b0, memout}, 32'd0);
        chk("R11 err_addr", err_addr, 32'd0);
        chk("R11 rd_data", rd_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: second miss does not overwrite, then R10 clear and recapture
        access(32'h1000_5000, 1'b0, 1'b0);
        access(32'h2000_4000, 1'b1, 1'b0);
        chk("R9 first kept", err_addr, 32'h1000_5000);
        access(32'h1000_7000, 1'b0, 1'b1);
        chk("R10 simultaneous", err_addr, 32'h1000_7000);
        clear();
        // R3: disabled window ignored, next window not reachable either
        bar_dis = 2'b01;
        access(32'h1000_0000, 1'b0, 1'b0);
        chk("R3 disabled window", {31'b0, rsp_claim}, 32'd0);
        bar_dis = 2'b00;

        for (int d = 0; d < 4; d++) begin
            bar_dis = d[1:0];
            for (int hi = 0; hi < 16; hi++) begin
                for (int oi = 0; oi < 8; oi++) begin
                    for (int w = 0; w < 2; w++) begin
                        tgt_data = 32'hCAFE_0000 ^ (hi << 8) ^ oi;
                        access((32'(hi) << 28) | off_of(oi), w[0], 1'b0);
                        cnt++;
                        if (cnt % 7 == 0) clear();
                    end
                end
            end
        end
        report();
    end

endmodule